// File: doc/BRIEF.md
# Decimal Mailbox Accumulator Processor

This block is a small stored-program processor. Instructions and data share one memory of 100 mailboxes. Every mailbox holds a decimal value from 0 to 999. A program is placed in memory while the core is held in reset. The core then fetches, decodes and executes words from mailbox 0 onward until it meets a halt word or an illegal word.

The only architectural state is an accumulator, a program counter and two status flags, overflow and negative. All four are visible on output ports. Inside the core, a memory address register, a memory data register and a current instruction register carry each word through the fetch sequence. The external memory answers a read one cycle after the core requests it. Input values arrive over a valid/ready handshake. Each output value is presented together with a one-cycle strobe.

An instruction word is split by its hundreds digit, which selects the operation. The remaining two digits, 00 to 99, give a mailbox address.

Top module: `deca_core`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, the following all read zero: `pc_o`, `acc_o`, `ovf_o`, `neg_o`, `err`, `halted`, `out_valid`, `in_ready` and `mem_we`.
- R2: Each instruction is read from the mailbox named by `pc_o`, and the program counter then steps by one, with 99 stepping to 0.
- R3: A word 1aa adds mailbox aa to the accumulator modulo 1000. It sets the overflow flag when the true sum exceeds 999 and clears it otherwise. It clears the negative flag.
- R4: A word 2aa subtracts mailbox aa from the accumulator modulo 1000. It sets the negative flag when the true difference is below zero and clears it otherwise. It clears the overflow flag.
- R5: A word 3aa writes the accumulator into mailbox aa. A word 5aa loads mailbox aa into the accumulator. Neither word, nor 901, nor 902, changes the flags.
- R6: Word 901 raises `in_ready` and waits with the program counter and accumulator unchanged. The first cycle in which `in_valid` is high, it copies `in_data` into the accumulator.
- R7: Word 902 raises `out_valid` for exactly one cycle, with `out_data` equal to the accumulator.
- R8: Word 6aa always loads aa into the program counter. Word 7aa does so only when the accumulator is 0. Word 8aa does so only when the negative flag is clear.
- R9: Word 000 halts the core. Once `halted` is high, `pc_o` and `acc_o` hold, and no memory access or output strobe occurs.
- R10: Any word not listed in R3 to R9 (hundreds digit 4, 0xx other than 000, or 9xx other than 901 and 902) halts the core with `err` high.
- R11: Timing from the rising edge of `rst_n`: words 1aa, 2aa and 5aa take 8 cycles each, every other word takes 5 cycles, and a 901 additionally takes one cycle for each cycle it waits. `halted` is high at the end of the 000 word's fifth cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 7 | Mailbox address for read or write |
| mem_rd | output | 1 | Read request; data is returned on `mem_rdata` in the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 10 | Write data (the accumulator) |
| mem_rdata | input | 10 | Read data, one cycle after `mem_rd` |
| in_data | input | 10 | Input value |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Core is waiting for an input value |
| out_data | output | 10 | Output value |
| out_valid | output | 1 | One-cycle strobe qualifying `out_data` |
| acc_o | output | 10 | Accumulator |
| pc_o | output | 7 | Program counter |
| ovf_o | output | 1 | Overflow flag |
| neg_o | output | 1 | Negative flag |
| halted | output | 1 | Core has stopped |
| err | output | 1 | Core stopped on an illegal word |

## Verification
Each program's results have fixed deadlines. The final accumulator, program counter, flags and memory image are due on the cycle `halted` rises. That cycle falls 5 cycles per plain word and 8 per memory-operand word after reset is released, plus any input wait. Every output strobe comes in the cycle after its 902 word executes. The bench counts clock edges from the release of reset and samples every port on the falling edge. It compares the edge count at which `halted` is first seen against the sum computed by its own instruction-level model. It records strobes on the falling edge that follows each rising edge. During a forced input stall, it samples the held state at a fixed edge count.

// File: rtl/deca_pkg.sv
// Package: shared types for the decimal mailbox processor.
// Assumes: nothing; holds only the control states and the decoded operations.
package deca_pkg;

    // Control states of the fetch / decode / execute sequence.
    typedef enum logic [3:0] {
        ST_FETCH,   // MAR takes PC
        ST_FWAIT,   // memory read of instruction requested
        ST_FLOAD,   // MDR takes returned word
        ST_DECODE,  // CIR takes MDR, PC steps
        ST_EXEC,    // act on decoded word
        ST_DADDR,   // memory read of operand requested
        ST_DWAIT,   // MDR takes operand
        ST_DEXEC,   // write back operand result
        ST_HALT     // stopped
    } state_t;

    // Decoded operations.
    typedef enum logic [3:0] {
        OP_HLT,
        OP_ADD,
        OP_SUB,
        OP_STA,
        OP_LDA,
        OP_BRA,
        OP_BRZ,
        OP_BRP,
        OP_INP,
        OP_OUT,
        OP_BAD
    } op_t;

endpackage

// File: rtl/deca_decode.sv
// Module: deca_decode
// Splits a decimal instruction word into an operation (hundreds digit)
// and a mailbox address (lower two digits).
// Assumes: word_i lies in 0 .. 10*SLOTS-1; SLOTS fits in ADDR_W bits.
module deca_decode import deca_pkg::*; #(
    parameter int WORD_W = 10,
    parameter int ADDR_W = 7,
    parameter int SLOTS  = 100
) (
    input  logic [WORD_W-1:0] word_i,
    output op_t               op_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [WORD_W-1:0] SL    = WORD_W'(SLOTS);
    localparam logic [WORD_W-1:0] W_INP = WORD_W'(9 * SLOTS + 1);
    localparam logic [WORD_W-1:0] W_OUT = WORD_W'(9 * SLOTS + 2);

    logic [WORD_W-1:0] digit;

    // Divide into digit and address, then map the digit to an operation.
    always_comb begin
        digit  = word_i / SL;
        addr_o = ADDR_W'(word_i - digit * SL);
        case (digit)
            WORD_W'(0): op_o = (word_i == '0) ? OP_HLT : OP_BAD;
            WORD_W'(1): op_o = OP_ADD;
            WORD_W'(2): op_o = OP_SUB;
            WORD_W'(3): op_o = OP_STA;
            WORD_W'(5): op_o = OP_LDA;
            WORD_W'(6): op_o = OP_BRA;
            WORD_W'(7): op_o = OP_BRZ;
            WORD_W'(8): op_o = OP_BRP;
            WORD_W'(9): op_o = (word_i == W_INP) ? OP_INP :
                               (word_i == W_OUT) ? OP_OUT : OP_BAD;
            default:    op_o = OP_BAD;
        endcase
    end

endmodule

// File: rtl/deca_alu.sv
// Module: deca_alu
// Decimal-range add and subtract modulo MODULUS with overflow and negative flags.
// Assumes: both operands are below MODULUS; MODULUS fits in WORD_W bits.
module deca_alu #(
    parameter int WORD_W  = 10,
    parameter int MODULUS = 1000
) (
    input  logic [WORD_W-1:0] acc_i,
    input  logic [WORD_W-1:0] opd_i,
    input  logic              sub_i,
    output logic [WORD_W-1:0] res_o,
    output logic              ovf_o,
    output logic              neg_o
);

    localparam int            EW   = WORD_W + 1;
    localparam logic [EW-1:0] MODV = EW'(MODULUS);

    logic [EW-1:0] a_ext;
    logic [EW-1:0] b_ext;
    logic [EW-1:0] sum;

    // Compute the wrapped result and the flag for the chosen operation.
    always_comb begin
        a_ext = {1'b0, acc_i};
        b_ext = {1'b0, opd_i};
        ovf_o = 1'b0;
        neg_o = 1'b0;
        if (!sub_i) begin
            sum = a_ext + b_ext;
            if (sum >= MODV) begin
                sum   = sum - MODV;
                ovf_o = 1'b1;
            end
        end else if (a_ext >= b_ext) begin
            sum = a_ext - b_ext;
        end else begin
            sum   = a_ext + MODV - b_ext;
            neg_o = 1'b1;
        end
        res_o = WORD_W'(sum);
    end

    // Guard: an in-range pair never yields an out-of-range result.
    always_comb begin
        if ({1'b0, acc_i} < MODV && {1'b0, opd_i} < MODV) begin
            // R3
            res_range_chk: assert ({1'b0, res_o} < MODV);
        end
    end

endmodule

// File: rtl/deca_core.sv
// Module: deca_core (top)
// Stored-program accumulator processor over a shared mailbox memory.
// Assumes: external memory returns read data one cycle after mem_rd;
// memory and input values are below MODULUS.
module deca_core import deca_pkg::*; #(
    parameter int WORD_W  = 10,
    parameter int ADDR_W  = 7,
    parameter int SLOTS   = 100,
    parameter int MODULUS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    output logic [WORD_W-1:0] acc_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              ovf_o,
    output logic              neg_o,
    output logic              halted,
    output logic              err
);

    localparam logic [ADDR_W-1:0] LAST_SLOT = ADDR_W'(SLOTS - 1);

    state_t            state;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] mar;
    logic [WORD_W-1:0] mdr;
    logic [WORD_W-1:0] cir;
    logic [WORD_W-1:0] acc;
    logic              ovf;
    logic              neg;
    logic              err_q;
    logic              out_v_q;
    logic [WORD_W-1:0] out_d_q;

    op_t               op;
    logic [ADDR_W-1:0] op_addr;
    logic [WORD_W-1:0] alu_res;
    logic              alu_ovf;
    logic              alu_neg;
    logic [ADDR_W-1:0] pc_step;

    deca_decode #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W),
        .SLOTS  (SLOTS)
    ) u_decode (
        .word_i (cir),
        .op_o   (op),
        .addr_o (op_addr)
    );

    deca_alu #(
        .WORD_W  (WORD_W),
        .MODULUS (MODULUS)
    ) u_alu (
        .acc_i (acc),
        .opd_i (mdr),
        .sub_i (op == OP_SUB),
        .res_o (alu_res),
        .ovf_o (alu_ovf),
        .neg_o (alu_neg)
    );

    // Next sequential program counter, wrapping after the last mailbox.
    assign pc_step = (pc == LAST_SLOT) ? '0 : pc + ADDR_W'(1);

    // Memory and handshake strobes follow the control state.
    always_comb begin
        mem_rd    = (state == ST_FWAIT) || (state == ST_DADDR);
        mem_we    = (state == ST_EXEC) && (op == OP_STA);
        mem_addr  = (state == ST_EXEC) ? op_addr : mar;
        mem_wdata = acc;
        in_ready  = (state == ST_EXEC) && (op == OP_INP);
    end

    // Control sequence and architectural register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_FETCH;
            pc      <= '0;
            mar     <= '0;
            mdr     <= '0;
            cir     <= '0;
            acc     <= '0;
            ovf     <= 1'b0;
            neg     <= 1'b0;
            err_q   <= 1'b0;
            out_v_q <= 1'b0;
            out_d_q <= '0;
        end else begin
            out_v_q <= 1'b0;
            case (state)
                ST_FETCH: begin
                    mar   <= pc;
                    state <= ST_FWAIT;
                end
                ST_FWAIT: state <= ST_FLOAD;
                ST_FLOAD: begin
                    mdr   <= mem_rdata;
                    state <= ST_DECODE;
                end
                ST_DECODE: begin
                    cir   <= mdr;
                    pc    <= pc_step;
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    state <= ST_FETCH;
                    case (op)
                        OP_ADD, OP_SUB, OP_LDA: begin
                            mar   <= op_addr;
                            state <= ST_DADDR;
                        end
                        OP_STA: ;
                        OP_INP: begin
                            if (in_valid) acc   <= in_data;
                            else          state <= ST_EXEC;
                        end
                        OP_OUT: begin
                            out_v_q <= 1'b1;
                            out_d_q <= acc;
                        end
                        OP_BRA: pc <= op_addr;
                        OP_BRZ: if (acc == '0) pc <= op_addr;
                        OP_BRP: if (!neg)      pc <= op_addr;
                        OP_HLT: state <= ST_HALT;
                        default: begin
                            err_q <= 1'b1;
                            state <= ST_HALT;
                        end
                    endcase
                end
                ST_DADDR: state <= ST_DWAIT;
                ST_DWAIT: begin
                    mdr   <= mem_rdata;
                    state <= ST_DEXEC;
                end
                ST_DEXEC: begin
                    if (op == OP_LDA) begin
                        acc <= mdr;
                    end else begin
                        acc <= alu_res;
                        ovf <= alu_ovf;
                        neg <= alu_neg;
                    end
                    state <= ST_FETCH;
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    assign acc_o     = acc;
    assign pc_o      = pc;
    assign ovf_o     = ovf;
    assign neg_o     = neg;
    assign err       = err_q;
    assign out_valid = out_v_q;
    assign out_data  = out_d_q;
    assign halted    = (state == ST_HALT);

    // R2
    fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FWAIT) |-> (mem_addr == pc));

    // R6
    inp_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> (in_ready && $stable(acc) && $stable(pc)));

    // R7
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc) && $stable(acc) && !mem_rd && !mem_we));

    // R10
    err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> halted);

endmodule

// File: tb/deca_core_bench.sv
`timescale 1ns/1ps
module deca_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] mem_addr;
    logic       mem_rd, mem_we;
    logic [9:0] mem_wdata;
    logic [9:0] mem_rdata = '0;
    logic [9:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [9:0] out_data;
    logic       out_valid;
    logic [9:0] acc_o;
    logic [6:0] pc_o;
    logic       ovf_o, neg_o, halted, err;

    always #5 clk = ~clk;

    deca_core u_deca_core (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .acc_o(acc_o),
        .pc_o(pc_o), .ovf_o(ovf_o), .neg_o(neg_o), .halted(halted), .err(err)
    );

    // Mailbox memory model with a preload port and one-cycle read latency.
    logic [9:0] mem [100];
    logic       ld_en = 1'b0;
    int         ld_addr = 0;
    logic [9:0] ld_data = '0;
    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_we && mem_addr < 7'd100) mem[mem_addr] <= mem_wdata;
        if (mem_rd && mem_addr < 7'd100) mem_rdata <= mem[mem_addr];
    end

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    int img [100];
    int inps [64];
    int ninp;

    int e_mem [100];
    int e_out [64];
    int e_nout, e_acc, e_ovf, e_neg, e_err, e_pc, e_cyc;

    int got_out [64];
    int got_nout, edges;

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 100; i++) img[i] = 0;
        for (int i = 0; i < 64; i++) inps[i] = 0;
        ninp = 0;
    endtask

    // Instruction-level reference model with cycle costs from the requirements.
    task automatic model_run();
        int pc, acc, ovf, neg, ii, w, h, a;
        pc = 0; acc = 0; ovf = 0; neg = 0; ii = 0;
        e_nout = 0; e_err = 0; e_cyc = 0;
        for (int i = 0; i < 100; i++) e_mem[i] = img[i];
        for (int step = 0; step < 2000; step++) begin
            w = e_mem[pc]; h = w / 100; a = w % 100;
            pc = (pc + 1) % 100;
            e_cyc += 5;
            if (w == 0) break;
            else if (h == 1 || h == 2 || h == 5) begin
                e_cyc += 3;
                if (h == 5) acc = e_mem[a];
                else if (h == 1) begin
                    acc = acc + e_mem[a]; ovf = (acc > 999); neg = 0;
                    if (acc > 999) acc -= 1000;
                end else begin
                    acc = acc - e_mem[a]; neg = (acc < 0); ovf = 0;
                    if (acc < 0) acc += 1000;
                end
            end
            else if (h == 3) e_mem[a] = acc;
            else if (h == 6) pc = a;
            else if (h == 7) begin if (acc == 0) pc = a; end
            else if (h == 8) begin if (neg == 0) pc = a; end
            else if (w == 901) begin acc = inps[ii]; if (ii < 63) ii++; end
            else if (w == 902) begin
                if (e_nout < 64) e_out[e_nout] = acc;
                e_nout++;
            end
            else begin e_err = 1; break; end
        end
        e_acc = acc; e_ovf = ovf; e_neg = neg; e_pc = pc;
    endtask

    // Load the image under reset, check reset state, run to halt, compare.
    task automatic run_prog(input int hold);
        int idx, quiet;
        bit take;
        int pc_hold;
        rst_n = 1'b0; in_valid = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); ld_en = 1'b1; ld_addr = i; ld_data = 10'(img[i]);
        end
        @(negedge clk); ld_en = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 pc", int'(pc_o), 0);
        chk("R1 acc", int'(acc_o), 0);
        chk("R1 flags", int'({ovf_o, neg_o, err, halted}), 0);
        chk("R1 strobes", int'({out_valid, in_ready, mem_we}), 0);
        model_run();
        rst_n = 1'b1;
        idx = 0; edges = 0; got_nout = 0;
        forever begin
            in_valid = (idx < ninp) && (edges >= hold);
            in_data  = 10'(inps[idx < 64 ? idx : 63]);
            #1;
            take = in_valid && in_ready;
            @(posedge clk);
            edges++;
            if (take) idx++;
            @(negedge clk);
            if (edges == 1) chk("R1 after release", int'({pc_o, acc_o}), 0);
            if (hold > 0 && edges == hold - 5) begin
                // R6: waiting on input, state held
                chk("R6 in_ready", int'(in_ready), 1);
                chk("R6 pc held", int'(pc_o), 1);
                chk("R6 acc held", int'(acc_o), 0);
            end
            if (out_valid) begin
                if (got_nout < 64) got_out[got_nout] = int'(out_data);
                got_nout++;
            end
            if (halted || edges > 3000) break;
        end
        in_valid = 1'b0;
        chk("R11 cycles to halt", edges, e_cyc + ((hold > 4) ? hold - 4 : 0));
        chk("R3 R4 R5 acc", int'(acc_o), e_acc);
        chk("R3 flag ovf", int'(ovf_o), e_ovf);
        chk("R4 flag neg", int'(neg_o), e_neg);
        chk("R10 err", int'(err), e_err);
        chk("R2 R8 pc", int'(pc_o), e_pc);
        chk("R7 output count", got_nout, e_nout);
        for (int i = 0; i < e_nout && i < got_nout && i < 64; i++)
            chk("R7 output value", got_out[i], e_out[i]);
        for (int i = 0; i < 100; i++) chk("R5 mailbox", int'(mem[i]), e_mem[i]);
        // R9: quiet and frozen after halt
        quiet = 0; pc_hold = int'(pc_o);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (mem_rd || mem_we || out_valid || !halted || int'(pc_o) != pc_hold) quiet++;
        end
        chk("R9 halted quiet", quiet, 0);
    endtask

    initial begin
        void'($urandom(32'd20457));
        // Add and subtract through memory with input and output.
        clear_img();
        img[0] = 901; img[1] = 350; img[2] = 901; img[3] = 150; img[4] = 902;
        img[5] = 901; img[6] = 250; img[7] = 902; img[8] = 0;
        inps[0] = 123; inps[1] = 456; inps[2] = 700; ninp = 3;
        run_prog(0);
        chk("R3 sum out", got_out[0], 579);
        chk("R4 diff out", got_out[1], 577);

        // Add wraps past 999 and sets overflow.
        clear_img();
        img[0] = 560; img[1] = 161; img[2] = 902; img[3] = 0;
        img[60] = 600; img[61] = 500;
        run_prog(0);
        chk("R3 wrapped sum", got_out[0], 100);
        chk("R3 ovf set", int'(ovf_o), 1);
        chk("R11 literal cycles", edges, 26);

        // Subtract below zero wraps and sets negative.
        clear_img();
        img[0] = 560; img[1] = 261; img[2] = 902; img[3] = 0;
        img[60] = 3; img[61] = 5;
        run_prog(0);
        chk("R4 wrapped diff", got_out[0], 998);
        chk("R4 neg set", int'(neg_o), 1);

        // Countdown loop with zero branch and unconditional branch.
        clear_img();
        img[0] = 570; img[1] = 902; img[2] = 271; img[3] = 705; img[4] = 601;
        img[5] = 0; img[70] = 3; img[71] = 1;
        run_prog(0);
        chk("R8 loop count", got_nout, 3);
        chk("R8 last out", got_out[2], 1);

        // Positive branch not taken then taken.
        clear_img();
        img[0] = 590; img[1] = 291; img[2] = 806; img[3] = 902; img[4] = 192;
        img[5] = 807; img[6] = 902; img[7] = 902; img[8] = 0;
        img[90] = 3; img[91] = 5; img[92] = 10;
        run_prog(0);
        chk("R8 brp outputs", got_nout, 2);
        chk("R8 brp second", got_out[1], 8);

        // Program counter wrap from 99 to 0; zero branch both ways.
        clear_img();
        img[0] = 705; img[1] = 0; img[5] = 597; img[6] = 699; img[99] = 902;
        img[97] = 42;
        run_prog(0);
        chk("R2 wrap out", got_out[0], 42);
        chk("R2 wrap pc", int'(pc_o), 2);

        // Illegal word stops with error.
        clear_img();
        img[0] = 580; img[1] = 400; img[2] = 902; img[3] = 0; img[80] = 7;
        run_prog(0);
        chk("R10 err raised", int'(err), 1);
        chk("R10 no output", got_nout, 0);

        // Input stall for 25 cycles.
        clear_img();
        img[0] = 901; img[1] = 902; img[2] = 0;
        inps[0] = 321; ninp = 1;
        run_prog(25);
        chk("R6 value taken", got_out[0], 321);

        // Random forward-only programs.
        for (int p = 0; p < 30; p++) begin
            int plen;
            clear_img();
            plen = 8 + int'($urandom % 24);
            for (int i = 40; i < 100; i++) img[i] = int'($urandom % 1000);
            for (int i = 0; i < plen - 1; i++) begin
                int d, t;
                d = 40 + int'($urandom % 60);
                t = i + 1 + int'($urandom % (plen - 1 - i));
                case ($urandom % 10)
                    0, 9: img[i] = 100 + d;
                    1: img[i] = 200 + d;
                    2: img[i] = 300 + d;
                    3: img[i] = 500 + d;
                    4: img[i] = 901;
                    5: img[i] = 902;
                    6: img[i] = 600 + t;
                    7: img[i] = 700 + t;
                    default: img[i] = 800 + t;
                endcase
            end
            img[plen - 1] = 0;
            if (p % 8 == 7) img[$urandom % (plen - 1)] = 400 + int'($urandom % 100);
            for (int i = 0; i < 64; i++) inps[i] = int'($urandom % 1000);
            ninp = 64;
            run_prog(0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL R11 watchdog: actual %0d expected %0d", 190000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule